// File: doc/BRIEF.md
# Zero-Idiom-Aware Load Address Classifier

This block sits beside register rename and sorts every renamed load into one of two address-generation classes: a short path for plain base-plus-small-offset addresses and a longer path for everything else. The decision is dynamic. For each architectural register the block holds one "known zero" flag. Only a register-with-itself XOR sets that flag. Any other write to the register clears it. When a load's index register carries the flag, the index contributes nothing to the address, so the load is put in the short class even though its encoding names an index.

Each cycle takes at most one renamed instruction: an opcode class, a destination, two source register numbers and, for loads, an index-present bit and a signed displacement. For a load, source A is the base and source B is the index. One cycle later the block presents a valid strobe, the class bit and the best-case load-to-use latency of that class. Flag lookups use the state as it stood before the same instruction's own write.

Top module: `zidx_addr_classifier`

## Requirements
- R1: A load with no index (in_has_index=0) whose displacement, read as signed, lies in 0..2047 is reported with out_simple=1.
- R2: A load whose displacement is negative or 2048 and above is reported with out_simple=0, even when its index carries the zero flag.
- R3: out_latency is 4 when out_simple=1 and 5 when out_simple=0, whenever out_valid is high.
- R4: A load with in_has_index=1 whose index register (in_src_b) lacks the zero flag is reported with out_simple=0.
- R5: An XOR (in_op=1) with in_src_a equal to in_src_b sets the zero flag of in_dst. An indexed load in the next cycle that uses that register as index and has an in-range displacement is reported with out_simple=1.
- R6: A move-immediate (in_op=2) never sets the flag, whatever its value, and it clears the flag of in_dst.
- R7: Every other register write clears the flag of in_dst: ALU (in_op=0), load (in_op=3), and XOR with differing sources.
- R8: When an instruction reads its index register and also writes it, the flag is looked up before that instruction's own write.
- R9: Reset (rst_n low, asynchronous) clears every flag and holds out_valid low.
- R10: out_valid is high exactly one cycle after an accepted load (in_valid=1, in_op=3). Codes 4 to 7, and any instruction presented with in_valid=0, leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode class: 0 ALU, 1 XOR, 2 move-immediate, 3 load, 4-7 no register write |
| in_dst | input | 4 | Destination register |
| in_src_a | input | 4 | Source A; base register for loads |
| in_src_b | input | 4 | Source B; index register for loads |
| in_has_index | input | 1 | Load uses an index register |
| in_disp | input | 32 | Signed load displacement |
| out_valid | output | 1 | Classification of the previous cycle's load is present |
| out_simple | output | 1 | 1 = short address path, 0 = full path |
| out_latency | output | 4 | Best-case load latency in cycles |

## Verification
A flag left stale or set by the wrong opcode shows up only when a later indexed load names that register. It then appears as a flipped out_simple and a latency one cycle off, one cycle after that load. The stimulus therefore pairs each flag-changing instruction with an indexed load placed right after it, and sometimes one instruction later. A wrong read-before-write order shows in the very next output of a load that overwrites its own index. Flag state lost or kept across reset shows on the first indexed load after release.

// File: rtl/zidx_pkg.sv
package zidx_pkg;

   typedef enum logic [2:0] {
      OPC_ALU  = 3'd0,
      OPC_XOR  = 3'd1,
      OPC_MOVI = 3'd2,
      OPC_LOAD = 3'd3,
      OPC_NOP  = 3'd4
   } zidx_opc_e;

   typedef struct packed {
      logic       wr_en;
      logic       wr_zero;
   } zidx_upd_t;

endpackage

// File: rtl/zidx_update_decode.sv
module zidx_update_decode
   import zidx_pkg::*;
#(
   parameter int REG_W = 4
) (
   input  logic             valid,
   input  logic [2:0]       op,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   output zidx_upd_t        upd
);

   zidx_opc_e opc;

   always_comb begin
      opc         = zidx_opc_e'(op);
      upd.wr_en   = 1'b0;
      upd.wr_zero = 1'b0;
      if (valid) begin
         unique case (opc)
            OPC_ALU, OPC_MOVI, OPC_LOAD: upd.wr_en = 1'b1;
            OPC_XOR: begin
               upd.wr_en   = 1'b1;
               upd.wr_zero = (src_a == src_b);
            end
            default: upd.wr_en = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/zidx_mark_file.sv
module zidx_mark_file
   import zidx_pkg::*;
#(
   parameter int NUM_REGS = 16,
   localparam int REG_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  zidx_upd_t        upd,
   input  logic [REG_W-1:0] wr_idx,
   input  logic [REG_W-1:0] rd_idx,
   output logic             rd_zero
);

   logic [NUM_REGS-1:0] mark_q;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_mark
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mark_q[g] <= 1'b0;
         end else if (upd.wr_en && (wr_idx == REG_W'(g))) begin
            mark_q[g] <= upd.wr_zero;
         end
      end
   end

   // Read sees the flag as held before this cycle's update.
   assign rd_zero = mark_q[rd_idx];

endmodule

// File: rtl/zidx_agen_class.sv
module zidx_agen_class #(
   parameter int DISP_W            = 32,
   parameter int SIMPLE_DISP_LIMIT = 2048,
   parameter int LAT_W             = 4,
   parameter int LAT_SIMPLE        = 4,
   parameter int LAT_COMPLEX       = 5,
   parameter bit HONOR_ZERO_MARK   = 1'b1
) (
   input  logic              has_index,
   input  logic [DISP_W-1:0] disp,
   input  logic              idx_zero,
   output logic              simple,
   output logic [LAT_W-1:0]  latency
);

   localparam logic [DISP_W-1:0] LIMIT_V = DISP_W'(SIMPLE_DISP_LIMIT);
   localparam logic [LAT_W-1:0]  LAT_S_V = LAT_W'(LAT_SIMPLE);
   localparam logic [LAT_W-1:0]  LAT_C_V = LAT_W'(LAT_COMPLEX);

   logic disp_ok;
   logic index_free;

   assign disp_ok = !disp[DISP_W-1] && (disp < LIMIT_V);

   if (HONOR_ZERO_MARK) begin : g_dynamic
      assign index_free = !has_index || idx_zero;
   end else begin : g_static
      logic unused_zero;
      assign unused_zero = idx_zero;
      assign index_free  = !has_index;
   end

   assign simple  = disp_ok && index_free;
   assign latency = simple ? LAT_S_V : LAT_C_V;

endmodule

// File: rtl/zidx_addr_classifier.sv
module zidx_addr_classifier
   import zidx_pkg::*;
#(
   parameter int NUM_REGS          = 16,
   parameter int DISP_W            = 32,
   parameter int SIMPLE_DISP_LIMIT = 2048,
   parameter int LAT_W             = 4,
   parameter int LAT_SIMPLE        = 4,
   parameter int LAT_COMPLEX       = 5,
   parameter bit HONOR_ZERO_MARK   = 1'b1,
   localparam int REG_W            = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [REG_W-1:0]  in_dst,
   input  logic [REG_W-1:0]  in_src_a,
   input  logic [REG_W-1:0]  in_src_b,
   input  logic              in_has_index,
   input  logic [DISP_W-1:0] in_disp,
   output logic              out_valid,
   output logic              out_simple,
   output logic [LAT_W-1:0]  out_latency
);

   if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (DISP_W < 2 || DISP_W > 32 || SIMPLE_DISP_LIMIT < 1 ||
       SIMPLE_DISP_LIMIT >= (1 << (DISP_W - 1))) begin : g_bad_disp
      $error("SIMPLE_DISP_LIMIT must fit the positive range of DISP_W");
   end
   if (LAT_SIMPLE >= LAT_COMPLEX || LAT_COMPLEX >= (1 << LAT_W)) begin : g_bad_lat
      $error("latencies must be ordered and fit LAT_W");
   end

   zidx_upd_t        upd;
   logic             idx_zero;
   logic             cls_simple;
   logic [LAT_W-1:0] cls_lat;
   logic             is_load;

   assign is_load = in_valid && (zidx_opc_e'(in_op) == OPC_LOAD);

   zidx_update_decode #(.REG_W(REG_W)) u_dec (
      .valid (in_valid),
      .op    (in_op),
      .src_a (in_src_a),
      .src_b (in_src_b),
      .upd   (upd)
   );

   zidx_mark_file #(.NUM_REGS(NUM_REGS)) u_marks (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (upd),
      .wr_idx  (in_dst),
      .rd_idx  (in_src_b),
      .rd_zero (idx_zero)
   );

   zidx_agen_class #(
      .DISP_W            (DISP_W),
      .SIMPLE_DISP_LIMIT (SIMPLE_DISP_LIMIT),
      .LAT_W             (LAT_W),
      .LAT_SIMPLE        (LAT_SIMPLE),
      .LAT_COMPLEX       (LAT_COMPLEX),
      .HONOR_ZERO_MARK   (HONOR_ZERO_MARK)
   ) u_cls (
      .has_index (in_has_index),
      .disp      (in_disp),
      .idx_zero  (idx_zero),
      .simple    (cls_simple),
      .latency   (cls_lat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_simple  <= 1'b0;
         out_latency <= '0;
      end else begin
         out_valid <= is_load;
         if (is_load) begin
            out_simple  <= cls_simple;
            out_latency <= cls_lat;
         end
      end
   end

endmodule

// File: rtl/zidx_checker.sv
module zidx_checker #(
   parameter int REG_W             = 4,
   parameter int DISP_W            = 32,
   parameter int SIMPLE_DISP_LIMIT = 2048,
   parameter int LAT_W             = 4,
   parameter int LAT_SIMPLE        = 4,
   parameter int LAT_COMPLEX       = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        in_op,
   input logic [REG_W-1:0]  in_dst,
   input logic [REG_W-1:0]  in_src_a,
   input logic [REG_W-1:0]  in_src_b,
   input logic              in_has_index,
   input logic [DISP_W-1:0] in_disp,
   input logic              out_valid,
   input logic              out_simple,
   input logic [LAT_W-1:0]  out_latency
);

   logic ld, in_range, xor_self, movi;
   assign ld       = in_valid && (in_op == 3'd3);
   assign in_range = !in_disp[DISP_W-1] && (in_disp < DISP_W'(SIMPLE_DISP_LIMIT));
   assign xor_self = in_valid && (in_op == 3'd1) && (in_src_a == in_src_b);
   assign movi     = in_valid && (in_op == 3'd2);

   assert_load_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> out_valid);
   assert_no_stray_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> !out_valid);
   assert_far_disp_complex_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !in_range) |=> !out_simple);
   assert_plain_small_simple_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && in_range && !in_has_index) |=> out_simple);
   assert_lat_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_simple) |-> (out_latency == LAT_W'(LAT_SIMPLE)));
   assert_lat_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_simple) |-> (out_latency == LAT_W'(LAT_COMPLEX)));
   assert_idiom_frees_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && in_has_index && in_range && $past(rst_n) && $past(xor_self) &&
       ($past(in_dst) == in_src_b)) |=> out_simple);
   assert_movi_not_idiom_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && in_has_index && $past(rst_n) && $past(movi) &&
       ($past(in_dst) == in_src_b)) |=> !out_simple);

endmodule

bind zidx_addr_classifier zidx_checker #(
   .REG_W             (REG_W),
   .DISP_W            (DISP_W),
   .SIMPLE_DISP_LIMIT (SIMPLE_DISP_LIMIT),
   .LAT_W             (LAT_W),
   .LAT_SIMPLE        (LAT_SIMPLE),
   .LAT_COMPLEX       (LAT_COMPLEX)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_op        (in_op),
   .in_dst       (in_dst),
   .in_src_a     (in_src_a),
   .in_src_b     (in_src_b),
   .in_has_index (in_has_index),
   .in_disp      (in_disp),
   .out_valid    (out_valid),
   .out_simple   (out_simple),
   .out_latency  (out_latency)
);

// File: tb/zidx_addr_classifier_test.sv
module zidx_addr_classifier_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  in_op;
   logic [3:0]  in_dst, in_src_a, in_src_b;
   logic        in_has_index;
   logic [31:0] in_disp;
   logic        out_valid, out_simple;
   logic [3:0]  out_latency;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   zidx_addr_classifier uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_has_index(in_has_index), .in_disp(in_disp),
      .out_valid(out_valid), .out_simple(out_simple), .out_latency(out_latency)
   );

   typedef struct packed {
      logic [23:0] tag;
      logic [2:0]  op;
      logic [3:0]  dst;
      logic [3:0]  a;
      logic [3:0]  b;
      logic        idx;
      logic [31:0] disp;
      logic        ev;
      logic        es;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{"R1",  3'd3, 4'd1,  4'd2,  4'd0,  1'b0, 32'd100,        1'b1, 1'b1},
      '{"R1",  3'd3, 4'd1,  4'd2,  4'd0,  1'b0, 32'd2047,       1'b1, 1'b1},
      '{"R2",  3'd3, 4'd1,  4'd2,  4'd0,  1'b0, 32'd2048,       1'b1, 1'b0},
      '{"R2",  3'd3, 4'd1,  4'd2,  4'd0,  1'b0, 32'hFFFF_FFF8,  1'b1, 1'b0},
      '{"R4",  3'd3, 4'd1,  4'd2,  4'd5,  1'b1, 32'd0,          1'b1, 1'b0},
      '{"R5",  3'd1, 4'd5,  4'd5,  4'd5,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R5",  3'd3, 4'd1,  4'd2,  4'd5,  1'b1, 32'd16,         1'b1, 1'b1},
      '{"R2",  3'd3, 4'd1,  4'd2,  4'd5,  1'b1, 32'd4000,       1'b1, 1'b0},
      '{"R6",  3'd2, 4'd6,  4'd0,  4'd0,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R6",  3'd3, 4'd1,  4'd2,  4'd6,  1'b1, 32'd8,          1'b1, 1'b0},
      '{"R7",  3'd0, 4'd5,  4'd3,  4'd4,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R7",  3'd3, 4'd1,  4'd2,  4'd5,  1'b1, 32'd8,          1'b1, 1'b0},
      '{"R5",  3'd1, 4'd7,  4'd7,  4'd7,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R10", 3'd4, 4'd7,  4'd1,  4'd2,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R8",  3'd3, 4'd7,  4'd2,  4'd7,  1'b1, 32'd4,          1'b1, 1'b1},
      '{"R8",  3'd3, 4'd1,  4'd2,  4'd7,  1'b1, 32'd4,          1'b1, 1'b0},
      '{"R5",  3'd1, 4'd8,  4'd8,  4'd8,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R7",  3'd1, 4'd8,  4'd3,  4'd4,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R7",  3'd3, 4'd1,  4'd2,  4'd8,  1'b1, 32'd0,          1'b1, 1'b0},
      '{"R5",  3'd1, 4'd9,  4'd9,  4'd9,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R6",  3'd2, 4'd9,  4'd0,  4'd0,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R6",  3'd3, 4'd1,  4'd2,  4'd9,  1'b1, 32'd0,          1'b1, 1'b0},
      '{"R5",  3'd1, 4'd15, 4'd15, 4'd15, 1'b0, 32'd0,          1'b0, 1'b0},
      '{"R5",  3'd3, 4'd1,  4'd2,  4'd15, 1'b1, 32'd2047,       1'b1, 1'b1},
      '{"R10", 3'd7, 4'd15, 4'd0,  4'd0,  1'b0, 32'd0,          1'b0, 1'b0},
      '{"R10", 3'd3, 4'd1,  4'd2,  4'd15, 1'b1, 32'd0,          1'b1, 1'b1}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input logic [23:0] tag, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(input bit v, input logic [2:0] op, input logic [3:0] d,
                        input logic [3:0] a, input logic [3:0] b,
                        input logic idx, input logic [31:0] disp);
      in_valid = v; in_op = op; in_dst = d; in_src_a = a; in_src_b = b;
      in_has_index = idx; in_disp = disp;
   endtask

   task automatic expect_out(input logic ev, input logic es, input logic [23:0] tag);
      chk({31'd0, out_valid}, {31'd0, ev}, tag, "out_valid");
      if (ev) begin
         chk({31'd0, out_simple}, {31'd0, es}, tag, "out_simple");
         chk({28'd0, out_latency}, es ? 32'd4 : 32'd5, "R3", "out_latency");
      end
   endtask

   initial begin
      rst_n = 1'b0;
      drive(1'b0, 3'd4, 4'd0, 4'd0, 4'd0, 1'b0, 32'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({31'd0, out_valid}, 32'd0, "R9", "out_valid in reset");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VECS[i].op, VECS[i].dst, VECS[i].a, VECS[i].b,
               VECS[i].idx, VECS[i].disp);
         @(negedge clk);
         expect_out(VECS[i].ev, VECS[i].es, VECS[i].tag);
      end

      // R10: a load presented without in_valid gives no strobe
      drive(1'b0, 3'd3, 4'd1, 4'd2, 4'd0, 1'b0, 32'd0);
      @(negedge clk);
      expect_out(1'b0, 1'b0, "R10");

      // R10: an XOR idiom presented without in_valid sets no flag
      drive(1'b0, 3'd1, 4'd4, 4'd4, 4'd4, 1'b0, 32'd0);
      @(negedge clk);
      drive(1'b1, 3'd3, 4'd1, 4'd2, 4'd4, 1'b1, 32'd0);
      @(negedge clk);
      expect_out(1'b1, 1'b0, "R10");

      // R9: flag set, then reset, then indexed load must be complex
      drive(1'b1, 3'd1, 4'd3, 4'd3, 4'd3, 1'b0, 32'd0);
      @(negedge clk);
      drive(1'b1, 3'd3, 4'd1, 4'd2, 4'd0, 1'b0, 32'd0);
      rst_n = 1'b0;
      @(negedge clk);
      chk({31'd0, out_valid}, 32'd0, "R9", "out_valid in reset");
      rst_n = 1'b1;
      drive(1'b1, 3'd3, 4'd1, 4'd2, 4'd3, 1'b1, 32'd0);
      @(negedge clk);
      expect_out(1'b1, 1'b0, "R9");

      drive(1'b0, 3'd4, 4'd0, 4'd0, 4'd0, 1'b0, 32'd0);
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule